// File: doc/BRIEF.md
# Status Register with Block Write Protection

This block keeps the status byte of a serial memory device and decides, cycle by cycle, whether a program command may proceed. The command decoder in front of it hands over one-cycle strobes: set or clear the write-enable latch, commit a status write with its data byte, and commit a memory program. The block also receives the target array address, the level of the active-low write-protect pin and a busy level from the programming sequencer.

Two combinational outputs grant or refuse writes. A memory write needs the write-enable latch, an idle device and an address outside the range fenced off by the two block-protect bits. A status write needs the latch, an idle device, and either a high write-protect pin or a cleared pin-enable bit. The status byte reads back the stored fields together with the busy flag and the page-protection result flag. While the device is busy it reads as all ones and every strobe is ignored.

Top module: `wprot_status_reg`

## Requirements
- R1: After reset, with busy low, the status byte reads 0x70: write-enable latch 0, both protect bits 0, pin-enable bit 0, page-result flag 1.
- R2: With busy low, the status byte is laid out as: bit 0 busy (0), bit 1 write-enable latch, bit 2 protect bit P0, bit 3 protect bit P1, bits 4 and 5 always 1, bit 6 page-result flag, bit 7 pin-enable bit.
- R3: With busy low, a program strobe (status or memory commit) clears the write-enable latch; otherwise the disable strobe clears it; otherwise the enable strobe sets it. Program strobes win over disable, disable wins over enable.
- R4: A status commit while status writes are granted loads P0 from data bit 2, P1 from data bit 3 and the pin-enable bit from data bit 7; data bits 0, 1, 4, 5 and 6 have no effect on the status byte.
- R5: Status writes are granted only when the latch is 1, busy is low, and the pin-enable bit is 0 or the pin is high. A refused status commit leaves P0, P1 and the pin-enable bit unchanged, so a set pin-enable bit stays set while the pin is low.
- R6: Memory writes are granted only when the latch is 1, busy is low and the address is unprotected; the pin level never affects this grant.
- R7: With {P1,P0} = 00 no address is protected; 01 protects the top quarter (0x600 to 0x7FF for 11 address bits); 10 protects the upper half (0x400 to 0x7FF); 11 protects every address.
- R8: While busy is high the status byte reads 0xFF, both grants are low, and the enable, disable, status commit and memory commit strobes have no effect on stored state.
- R9: A result-load strobe copies the result value into the page-result flag (bit 6), also while busy; the flag is 1 after reset.
- R10: Once a status commit has been taken, a later fall of the pin and a following busy period leave the stored protect and pin-enable bits as committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| set_wel_i | input | 1 | Write-enable command strobe |
| clr_wel_i | input | 1 | Write-disable command strobe |
| sr_wr_i | input | 1 | Status write commit strobe |
| sr_wdata_i | input | 8 | Byte carried by the status write |
| mem_wr_i | input | 1 | Memory program commit strobe |
| addr_i | input | ADDR_W | Target array address |
| wp_n_i | input | 1 | Write-protect pin, low protects the status byte |
| busy_i | input | 1 | Internal programming cycle in progress |
| ppa_load_i | input | 1 | Load strobe for the page-result flag |
| ppa_val_i | input | 1 | Value for the page-result flag |
| status_o | output | 8 | Status byte read-back |
| sr_wr_ok_o | output | 1 | Status write granted |
| mem_wr_ok_o | output | 1 | Memory write granted |

## Verification
Random cycles mix all strobes with random addresses, data bytes, pin levels and short busy bursts, so latch priority, refused status writes and the busy freeze are all hit against a reference model. Directed steps walk each protect setting across the edges of its range (0x3FF/0x400, 0x5FF/0x600, 0x000, 0x7FF), which separates an off-by-one range decode from a correct one. A pin-low refusal with the pin-enable bit set distinguishes the sticky behaviour from an unconditional write, and a pin-low memory grant shows the pin is kept away from the array path. Writing bytes with the don't-care bits set tells apart a layout that leaks data bits into the read-back.

// File: rtl/wps_pkg.sv
package wps_pkg;

    typedef struct packed {
        logic       wel;
        logic [1:0] bp;
        logic       wpen;
        logic       ppa;
    } wps_state_t;

    localparam logic [1:0] BP_NONE    = 2'b00;
    localparam logic [1:0] BP_QUARTER = 2'b01;
    localparam logic [1:0] BP_HALF    = 2'b10;
    localparam logic [1:0] BP_ALL     = 2'b11;

    localparam int SR_BP0  = 2;
    localparam int SR_BP1  = 3;
    localparam int SR_WPEN = 7;

endpackage

// File: rtl/wps_range_chk.sv
module wps_range_chk #(
    parameter int ADDR_W = 11
) (
    input  logic [1:0]        bp_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              locked_o
);
    import wps_pkg::*;

    localparam int TOP = ADDR_W - 1;

    always_comb begin
        case (bp_i)
            BP_NONE:    locked_o = 1'b0;
            BP_QUARTER: locked_o = &addr_i[TOP -: 2];
            BP_HALF:    locked_o = addr_i[TOP];
            default:    locked_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/wps_sr_guard.sv
module wps_sr_guard (
    input  logic wel_i,
    input  logic busy_i,
    input  logic wpen_i,
    input  logic wp_n_i,
    input  logic locked_i,
    output logic sr_ok_o,
    output logic mem_ok_o
);
    logic idle_armed;

    always_comb begin
        idle_armed = wel_i & ~busy_i;
        sr_ok_o    = idle_armed & (~wpen_i | wp_n_i);
        mem_ok_o   = idle_armed & ~locked_i;
    end

endmodule

// File: rtl/wprot_status_reg.sv
module wprot_status_reg #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_wel_i,
    input  logic              clr_wel_i,
    input  logic              sr_wr_i,
    input  logic [7:0]        sr_wdata_i,
    input  logic              mem_wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wp_n_i,
    input  logic              busy_i,
    input  logic              ppa_load_i,
    input  logic              ppa_val_i,
    output logic [7:0]        status_o,
    output logic              sr_wr_ok_o,
    output logic              mem_wr_ok_o
);
    import wps_pkg::*;

    localparam wps_state_t RST_STATE = '{wel: 1'b0, bp: BP_NONE, wpen: 1'b0, ppa: 1'b1};

    wps_state_t state_d, state_q;
    logic       locked;
    logic [1:0] bp_q;
    logic       wpen_q;
    logic       unused_data;

    assign bp_q        = state_q.bp;
    assign wpen_q      = state_q.wpen;
    assign unused_data = ^{sr_wdata_i[6:4], sr_wdata_i[1:0]};

    wps_range_chk #(.ADDR_W(ADDR_W)) u_range (
        .bp_i     (state_q.bp),
        .addr_i   (addr_i),
        .locked_o (locked)
    );

    wps_sr_guard u_guard (
        .wel_i    (state_q.wel),
        .busy_i   (busy_i),
        .wpen_i   (state_q.wpen),
        .wp_n_i   (wp_n_i),
        .locked_i (locked),
        .sr_ok_o  (sr_wr_ok_o),
        .mem_ok_o (mem_wr_ok_o)
    );

    always_comb begin
        state_d = state_q;
        if (ppa_load_i) begin
            state_d.ppa = ppa_val_i;
        end
        if (!busy_i) begin
            if (sr_wr_i || mem_wr_i) begin
                if (sr_wr_i && sr_wr_ok_o) begin
                    state_d.bp   = {sr_wdata_i[SR_BP1], sr_wdata_i[SR_BP0]};
                    state_d.wpen = sr_wdata_i[SR_WPEN];
                end
                state_d.wel = 1'b0;
            end else if (clr_wel_i) begin
                state_d.wel = 1'b0;
            end else if (set_wel_i) begin
                state_d.wel = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RST_STATE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        if (busy_i) begin
            status_o = 8'hFF;
        end else begin
            status_o = {state_q.wpen, state_q.ppa, 2'b11, state_q.bp, state_q.wel, 1'b0};
        end
    end

endmodule

// File: rtl/wps_checker.sv
module wps_checker #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_i,
    input logic              wp_n_i,
    input logic              sr_wr_i,
    input logic              mem_wr_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [7:0]        status_o,
    input logic              sr_wr_ok_o,
    input logic              mem_wr_ok_o,
    input logic [1:0]        bp_q,
    input logic              wpen_q
);

    AST_BUSY_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> (status_o == 8'hFF && !sr_wr_ok_o && !mem_wr_ok_o)); // R8

    AST_PROG_DROPS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_i && (sr_wr_i || mem_wr_i)) |=> (busy_i || !status_o[1])); // R3

    AST_WPEN_HELD_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_i && wpen_q && !wp_n_i) |=> wpen_q); // R5

    AST_REFUSED_KEEPS_BP: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_i && sr_wr_i && !sr_wr_ok_o) |=> $stable(bp_q)); // R5

    AST_MEM_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_ok_o |-> (status_o[1] && !busy_i)); // R6

    AST_ALL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_i && status_o[3:2] == 2'b11) |-> !mem_wr_ok_o); // R7

    AST_QUARTER_OPEN_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_i && status_o[3:2] == 2'b01 && status_o[1] && addr_i[ADDR_W-1 -: 2] != 2'b11)
            |-> mem_wr_ok_o); // R7

endmodule

bind wprot_status_reg wps_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_i      (busy_i),
    .wp_n_i      (wp_n_i),
    .sr_wr_i     (sr_wr_i),
    .mem_wr_i    (mem_wr_i),
    .addr_i      (addr_i),
    .status_o    (status_o),
    .sr_wr_ok_o  (sr_wr_ok_o),
    .mem_wr_ok_o (mem_wr_ok_o),
    .bp_q        (bp_q),
    .wpen_q      (wpen_q)
);

// File: tb/wprot_status_reg_bench.sv
module wprot_status_reg_bench;

    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          set_wel, clr_wel, sr_wr, mem_wr, wp_n, busy, ppa_load, ppa_val;
    logic [7:0]    wdat;
    logic [AW-1:0] addr;
    logic [7:0]    status_o;
    logic          sr_ok, mem_ok;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference model state
    logic       m_wel, m_wpen, m_ppa;
    logic [1:0] m_bp;

    always #5 clk = ~clk;

    wprot_status_reg #(.ADDR_W(AW)) u_wprot_status_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_wel_i   (set_wel),
        .clr_wel_i   (clr_wel),
        .sr_wr_i     (sr_wr),
        .sr_wdata_i  (wdat),
        .mem_wr_i    (mem_wr),
        .addr_i      (addr),
        .wp_n_i      (wp_n),
        .busy_i      (busy),
        .ppa_load_i  (ppa_load),
        .ppa_val_i   (ppa_val),
        .status_o    (status_o),
        .sr_wr_ok_o  (sr_ok),
        .mem_wr_ok_o (mem_ok)
    );

    function automatic logic [7:0] exp_status();
        if (busy) return 8'hFF;               // R8
        return {m_wpen, m_ppa, 2'b11, m_bp, m_wel, 1'b0}; // R2
    endfunction

    function automatic logic exp_locked(logic [AW-1:0] a);
        case (m_bp)                            // R7
            2'b00:   return 1'b0;
            2'b01:   return a >= AW'(12'h600);
            2'b10:   return a >= AW'(12'h400);
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic exp_srok();
        return m_wel && !busy && (!m_wpen || wp_n); // R5
    endfunction

    function automatic logic exp_memok();
        return m_wel && !busy && !exp_locked(addr); // R6
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        logic ok;
        ok = exp_srok();
        if (ppa_load) m_ppa = ppa_val;
        if (!busy) begin
            if (sr_wr || mem_wr) begin
                if (sr_wr && ok) begin
                    m_bp   = wdat[3:2];
                    m_wpen = wdat[7];
                end
                m_wel = 1'b0;
            end else if (clr_wel) m_wel = 1'b0;
            else if (set_wel) m_wel = 1'b1;
        end
    endtask

    task automatic idle_in();
        set_wel = 0; clr_wel = 0; sr_wr = 0; mem_wr = 0;
        ppa_load = 0; ppa_val = 0; busy = 0; wdat = 8'h00;
    endtask

    // inputs are already driven (after a falling edge); compare, then clock once
    task automatic cyc(string tag);
        #1;
        chk({tag, " status"}, status_o, exp_status());
        chk({tag, " sr_ok"}, {7'd0, sr_ok}, {7'd0, exp_srok()});
        chk({tag, " mem_ok"}, {7'd0, mem_ok}, {7'd0, exp_memok()});
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic do_wren();
        idle_in(); set_wel = 1; cyc("R3 wren");
        idle_in();
    endtask

    task automatic do_wrsr(logic [7:0] d);
        do_wren();
        sr_wr = 1; wdat = d; cyc("R4 wrsr");
        idle_in();
    endtask

    task automatic probe(string tag, logic [AW-1:0] a, logic exp_ok);
        addr = a;
        #1;
        chk(tag, {7'd0, mem_ok}, {7'd0, exp_ok});
        cyc(tag);
    endtask

    initial begin
        idle_in();
        wp_n = 1; addr = '0;
        m_wel = 0; m_wpen = 0; m_ppa = 1; m_bp = 2'b00;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset value
        #1; chk("R1 reset status", status_o, 8'h70);
        cyc("R1");

        // R3 enable then disable, disable beats enable
        do_wren();
        #1; chk("R3 wel set", status_o, 8'h72);
        set_wel = 1; clr_wel = 1; cyc("R3 both");
        idle_in();
        #1; chk("R3 disable wins", status_o, 8'h70);

        // R4 + R2: data don't-care bits must not leak
        do_wrsr(8'h7F);            // bp=11, wpen=0, other bits set
        #1; chk("R4 R2 dontcare", status_o, 8'h7C);
        do_wrsr(8'h88);            // bp=10, wpen=1
        #1; chk("R4 load bp/wpen", status_o, 8'hF8);

        // R5 sticky pin-enable bit while pin low
        wp_n = 0;
        do_wren();
        #1; chk("R5 sr refused", {7'd0, sr_ok}, 8'h00);
        sr_wr = 1; wdat = 8'h00; cyc("R5 refused write");
        idle_in();
        #1; chk("R5 wpen kept", status_o, 8'hF8);

        // R6 pin does not affect memory grant
        do_wren();
        probe("R6 pin low mem ok", AW'(12'h3FF), 1'b1);
        wp_n = 1;

        // R7 range edges for each setting
        do_wrsr(8'h00);
        do_wren(); probe("R7 none 7FF", AW'(12'h7FF), 1'b1);
        do_wrsr(8'h04);
        do_wren(); probe("R7 qtr 5FF", AW'(12'h5FF), 1'b1);
        do_wren(); probe("R7 qtr 600", AW'(12'h600), 1'b0);
        do_wren(); probe("R7 qtr 7FF", AW'(12'h7FF), 1'b0);
        do_wrsr(8'h08);
        do_wren(); probe("R7 half 3FF", AW'(12'h3FF), 1'b1);
        do_wren(); probe("R7 half 400", AW'(12'h400), 1'b0);
        do_wrsr(8'h0C);
        do_wren(); probe("R7 all 000", AW'(12'h000), 1'b0);

        // R8 busy freezes and reads ones
        do_wrsr(8'h04);
        do_wren();
        busy = 1; clr_wel = 1; cyc("R8 busy wrdi");
        busy = 1; clr_wel = 0; sr_wr = 1; wdat = 8'h8C; cyc("R8 busy wrsr");
        idle_in();
        #1; chk("R8 frozen", status_o, 8'h76);

        // R9 result flag, loaded also while busy
        busy = 1; ppa_load = 1; ppa_val = 0; cyc("R9 load busy");
        idle_in();
        #1; chk("R9 flag low", status_o, 8'h36);

        // R10 pin falls after commit, then busy period
        do_wrsr(8'h88);
        wp_n = 0; busy = 1; cyc("R10 busy");
        busy = 1; cyc("R10 busy");
        idle_in();
        #1; chk("R10 kept", status_o, 8'hB8);
        wp_n = 1;
        do_wrsr(8'h00);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            set_wel  = ($urandom % 3) == 0;
            clr_wel  = ($urandom % 6) == 0;
            sr_wr    = ($urandom % 5) == 0;
            mem_wr   = ($urandom % 5) == 0;
            wdat     = 8'($urandom);
            addr     = AW'($urandom);
            wp_n     = ($urandom % 3) != 0;
            busy     = ($urandom % 7) == 0;
            ppa_load = ($urandom % 9) == 0;
            ppa_val  = 1'($urandom);
            cyc("R2/R3/R5/R6/R8 random");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule